// File: doc/BRIEF.md
# PHY Delay-Register Access Port

This block gives host software a path to program the delay registers of a storage-card PHY through one 32-bit host register. The host register holds a six-bit PHY register address, an eight-bit value to write, two request bits (write and read) and two read-only items: the byte returned by the PHY and an acknowledge flag. Software loads the address and value first. It then sets one request bit in a later bus write and polls the acknowledge flag. When the flag is high it clears the request and waits for the flag to drop. Each transfer is a complete four-phase request/acknowledge exchange.

Behind the port sits a small PHY register-file model with 64 eight-bit registers. It answers a request after a fixed, parameterised number of cycles, so a transfer completes well within a software polling timeout of a few microseconds. The low addresses hold per-speed-mode input delays, and 0x0B to 0x0D hold the DLL delays for the card clock, the high-speed MMC clock and the data strobe. The model does not interpret any of these values.

Top module: `phyacc_port`

## Requirements
- R1: The host register layout is: address in bits [5:0], write value in [15:8], returned PHY byte in [23:16], write request in bit 24, read request in bit 25 and acknowledge in bit 26. Bits [31:27] and [7:6] read as 0. Bus writes to bits [23:16] and bit 26 have no effect.
- R2: After a synchronous active-low reset the host register reads 0 and every PHY register holds 0.
- R3: When acknowledge is low and a bus write leaves exactly one request bit set, acknowledge reads 1 exactly ACK_DELAY+1 cycles after that bus write, and not before.
- R4: Acknowledge stays high for as long as the accepted request bit stays set and the other request bit stays clear.
- R5: Acknowledge returns low one cycle after the accepted request is cleared.
- R6: A write request stores the write value at the addressed PHY register once, at the moment acknowledge rises.
- R7: A read request returns the addressed PHY register in bits [23:16] together with acknowledge. The value stays unchanged until the request is cleared.
- R8: If both request bits are set at once, no acknowledge is produced and no PHY register changes.
- R9: A request that is set while acknowledge is still high is not accepted until acknowledge has returned low. It then takes the full ACK_DELAY+1 cycles again.
- R10: All 64 addresses are independent. This includes the lowest address, 0x0D and the highest address 0x3F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the host register |
| bus_wdata | input | 32 | Host register write value |
| bus_rdata | output | 32 | Host register read value |

## Verification
The bench builds the block with ACK_DELAY set to 3. This keeps every handshake short, so the exact cycle of each acknowledge edge can be checked rather than only polled for. It also lets many transfers, including the request-swap and both-bits cases, fit into one short run. The 64-entry register file stays at its full size, so the boundary addresses 0x00 and 0x3F are reachable.

// File: rtl/phyacc_pkg.sv
// Shared field positions and state encoding for the PHY access port.
// Assumes a 32-bit host register; field positions are fixed by software.
package phyacc_pkg;
    localparam int ADDR_W    = 6;
    localparam int DATA_W    = 8;
    localparam int WORD_W    = 32;
    localparam int ADDR_LSB  = 0;
    localparam int WDATA_LSB = 8;
    localparam int RDATA_LSB = 16;
    localparam int WR_BIT    = 24;
    localparam int RD_BIT    = 25;
    localparam int ACK_BIT   = 26;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_ACK  = 2'd2
    } phy_state_e;
endpackage

// File: rtl/phyacc_host_reg.sv
// Host-side register of the access port. It holds the address, the write
// value and the two request bits written by software. It forwards them
// unchanged to the PHY side and returns the PHY byte and acknowledge on
// read. Assumes software runs the four-phase sequence; no protection here.
module phyacc_host_reg
    import phyacc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic              phy_ack,
    input  logic [DATA_W-1:0] phy_rdata,
    output logic [ADDR_W-1:0] phy_addr,
    output logic [DATA_W-1:0] phy_wdata,
    output logic              phy_wr,
    output logic              phy_rd
);
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              wr_q;
    logic              rd_q;
    logic              unused_bits;

    // Capture the software-writable fields on a bus write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            wr_q    <= 1'b0;
            rd_q    <= 1'b0;
        end else if (bus_wr) begin
            addr_q  <= bus_wdata[ADDR_LSB +: ADDR_W];
            wdata_q <= bus_wdata[WDATA_LSB +: DATA_W];
            wr_q    <= bus_wdata[WR_BIT];
            rd_q    <= bus_wdata[RD_BIT];
        end
    end

    // Assemble the host register read value.
    always_comb begin
        bus_rdata                          = '0;
        bus_rdata[ADDR_LSB +: ADDR_W]      = addr_q;
        bus_rdata[WDATA_LSB +: DATA_W]     = wdata_q;
        bus_rdata[RDATA_LSB +: DATA_W]     = phy_rdata;
        bus_rdata[WR_BIT]                  = wr_q;
        bus_rdata[RD_BIT]                  = rd_q;
        bus_rdata[ACK_BIT]                 = phy_ack;
    end

    assign phy_addr    = addr_q;
    assign phy_wdata   = wdata_q;
    assign phy_wr      = wr_q;
    assign phy_rd      = rd_q;
    assign unused_bits = ^{bus_wdata[WORD_W-1:ACK_BIT], bus_wdata[RDATA_LSB +: DATA_W],
                           bus_wdata[WDATA_LSB-1:ADDR_W]};

    // R8: with both requests set and no acknowledge pending, none appears.
    p_conflict_no_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_q && rd_q && !phy_ack) |=> !phy_ack);
endmodule

// File: rtl/phyacc_phy_model.sv
// PHY register-file model answering four-phase requests. A single request
// (write xor read) seen while idle starts a wait of ACK_DELAY cycles; the
// access happens as acknowledge rises and acknowledge holds until the
// accepted request is withdrawn or the other request bit also appears.
// Assumes ACK_DELAY >= 1.
module phyacc_phy_model
    import phyacc_pkg::*;
#(
    parameter int ACK_DELAY = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_wr,
    input  logic              req_rd,
    output logic              ack,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int CNT_W = $clog2(ACK_DELAY + 1);

    phy_state_e        state;
    logic [CNT_W-1:0]  cnt;
    logic              kind_rd;
    logic              active;
    logic              commit;
    logic [DATA_W-1:0] mem [DEPTH];

    // The accepted request is still the only one set.
    assign active = kind_rd ? (req_rd && !req_wr) : (req_wr && !req_rd);
    assign commit = (state == ST_WAIT) && active && (cnt == CNT_W'(ACK_DELAY - 1));
    assign ack    = (state == ST_ACK);

    // Handshake sequencing: idle, counted wait, acknowledge hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            kind_rd <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (req_wr ^ req_rd) begin
                    kind_rd <= req_rd;
                    cnt     <= '0;
                    state   <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (!active)     state <= ST_IDLE;
                    else if (commit) state <= ST_ACK;
                    else             cnt   <= cnt + 1'b1;
                end
                ST_ACK:  if (!active) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Register file update and read-data capture at acknowledge rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            rdata <= '0;
        end else if (commit) begin
            if (kind_rd) rdata         <= mem[req_addr];
            else         mem[req_addr] <= req_wdata;
        end
    end

    // R3: acknowledge only rises out of a live, accepted request.
    p_ack_from_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack) |-> $past(active));
    // R3: the wait counter never passes its limit.
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT) |-> (cnt < CNT_W'(ACK_DELAY)));
    // R4: acknowledge holds while the request stays.
    p_ack_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && active) |=> ack);
    // R5: acknowledge drops one cycle after the request goes.
    p_ack_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !active) |=> !ack);
    // R7: returned byte stays put while a read acknowledge is held.
    p_rdata_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && $past(ack) && kind_rd) |-> $stable(rdata));
endmodule

// File: rtl/phyacc_port.sv
// Top of the PHY access port: host register in front, PHY register-file
// model behind. ACK_DELAY sets the PHY answer latency in cycles and must
// stay far below the software polling timeout.
module phyacc_port
    import phyacc_pkg::*;
#(
    parameter int ACK_DELAY = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata
);
    logic [ADDR_W-1:0] phy_addr;
    logic [DATA_W-1:0] phy_wdata;
    logic [DATA_W-1:0] phy_rdata;
    logic              phy_wr;
    logic              phy_rd;
    logic              phy_ack;

    phyacc_host_reg u_host (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .phy_ack   (phy_ack),
        .phy_rdata (phy_rdata),
        .phy_addr  (phy_addr),
        .phy_wdata (phy_wdata),
        .phy_wr    (phy_wr),
        .phy_rd    (phy_rd)
    );

    phyacc_phy_model #(.ACK_DELAY(ACK_DELAY)) u_phy (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_addr  (phy_addr),
        .req_wdata (phy_wdata),
        .req_wr    (phy_wr),
        .req_rd    (phy_rd),
        .ack       (phy_ack),
        .rdata     (phy_rdata)
    );
endmodule

// File: tb/sim_phyacc_port.sv
module sim_phyacc_port;
    localparam int DLY = 3;
    localparam logic [31:0] WR = 32'h0100_0000;
    localparam logic [31:0] RD = 32'h0200_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    int          n_chk = 0;
    int          n_bad = 0;

    always #2 clk = ~clk;

    phyacc_port #(.ACK_DELAY(DLY)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] word(input logic [5:0] a, input logic [7:0] d);
        return {16'h0, d, 2'b00, a};
    endfunction

    task automatic bus_write(input logic [31:0] w);
        @(negedge clk); bus_wr = 1'b1; bus_wdata = w;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // R3 R4 R5 R6: full write handshake with cycle-exact acknowledge.
    task automatic phy_write(input logic [5:0] a, input logic [7:0] d);
        chk("R3 ack low before start", 32'(bus_rdata[26]), 0);
        bus_write(word(a, d));
        bus_write(word(a, d) | WR);
        wait_n(DLY);
        chk("R3 ack not early", 32'(bus_rdata[26]), 0);
        wait_n(1);
        chk("R3 ack rises", 32'(bus_rdata[26]), 1);
        wait_n(5);
        chk("R4 ack held", 32'(bus_rdata[26]), 1);
        bus_write(word(a, d));
        chk("R5 ack still high", 32'(bus_rdata[26]), 1);
        wait_n(1);
        chk("R5 ack dropped", 32'(bus_rdata[26]), 0);
    endtask

    // R7: read handshake, returned byte stable while held.
    task automatic phy_read(input logic [5:0] a, input logic [7:0] exp, input string req);
        bus_write(word(a, 8'h00) | RD);
        wait_n(DLY + 1);
        chk("R7 read ack", 32'(bus_rdata[26]), 1);
        chk(req, 32'(bus_rdata[23:16]), 32'(exp));
        wait_n(4);
        chk("R7 read data stable", 32'(bus_rdata[23:16]), 32'(exp));
        bus_write(word(a, 8'h00));
        wait_n(1);
        chk("R5 read ack dropped", 32'(bus_rdata[26]), 0);
    endtask

    task automatic t_reset();
        chk("R2 reset register", bus_rdata, 32'h0);
        phy_read(6'h0D, 8'h00, "R2 reset PHY reg 0x0D");
    endtask

    task automatic t_fields();
        bus_write(32'hF8FF_C3EA);
        wait_n(DLY + 2);
        chk("R1 field readback", bus_rdata, 32'h0000_C32A);
    endtask

    task automatic t_writes();
        phy_write(6'h00, 8'h11);
        phy_write(6'h0D, 8'hA5);
        phy_write(6'h3F, 8'h7E);
        phy_write(6'h0B, 8'h5A);
        phy_read(6'h00, 8'h11, "R10 addr 0x00");
        phy_read(6'h0D, 8'hA5, "R6 addr 0x0D");
        phy_read(6'h3F, 8'h7E, "R10 addr 0x3F");
        phy_read(6'h0B, 8'h5A, "R10 addr 0x0B");
        phy_write(6'h0D, 8'h3C);
        phy_read(6'h0D, 8'h3C, "R6 overwrite 0x0D");
        phy_read(6'h0C, 8'h00, "R10 neighbour untouched");
    endtask

    task automatic t_both();
        bus_write(word(6'h0C, 8'h99));
        bus_write(word(6'h0C, 8'h99) | WR | RD);
        wait_n(DLY + 1);
        chk("R8 no ack (on time)", 32'(bus_rdata[26]), 0);
        wait_n(6);
        chk("R8 no ack (late)", 32'(bus_rdata[26]), 0);
        bus_write(word(6'h0C, 8'h00));
        phy_read(6'h0C, 8'h00, "R8 register unchanged");
    endtask

    task automatic t_swap();
        bus_write(word(6'h05, 8'h66));
        bus_write(word(6'h05, 8'h66) | WR);
        wait_n(DLY + 1);
        chk("R9 write ack up", 32'(bus_rdata[26]), 1);
        bus_write(word(6'h05, 8'h00) | RD);
        chk("R9 ack still high", 32'(bus_rdata[26]), 1);
        wait_n(1);
        chk("R9 ack returns low", 32'(bus_rdata[26]), 0);
        wait_n(DLY);
        chk("R9 new request waits", 32'(bus_rdata[26]), 0);
        wait_n(1);
        chk("R9 new request acked", 32'(bus_rdata[26]), 1);
        chk("R9 read after swap", 32'(bus_rdata[23:16]), 32'h66);
        bus_write(word(6'h05, 8'h00));
        wait_n(1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);
        t_reset();
        t_fields();
        t_writes();
        t_both();
        t_swap();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule